// File: doc/BRIEF.md
# Ethernet Transmit Command Controller

This block sits between a host port and a MAC transmitter and decides when each outgoing frame may begin. The host writes a 16-bit command word together with the frame length. The block records the word, turns its fields into a start threshold, a collision retry limit and two per-frame flags, and then counts the bytes the host pushes into the transmit buffer. When the buffered count reaches the threshold, a single start pulse goes to the MAC. Lengths that are too short are refused at once.

A command with its force bit set drops the buffered data and, if a frame is already on the wire, ends it. The block raises an abort strobe and holds a bad-CRC flag toward the MAC until the MAC confirms the abort. If no confirmation arrives within 64 bit times, the block ends the abort itself and flags an error. The command register itself cannot be read. A readback port returns the last word written, with a fixed identifier in its low bits.

Top module: `tx_cmd_ctrl`

## Requirements
- R1: Command bits [7:6] pick the start threshold: 00 means 5 bytes, 01 means 381, 10 means 1021, and 11 means the full programmed length. The effective threshold is the smaller of that value and the programmed length. `mac_start` goes high in the cycle after the byte push that makes the count since the last command reach the effective threshold. A push in the same cycle as a command is the first byte of the new frame.
- R2: `mac_start` is a single-cycle pulse, at most one per command. It never fires while a frame is already active, and `frame_active` is high whenever `mac_start` is high.
- R3: A command whose length is below 3 gives a one-cycle `len_reject` pulse in the following cycle, and that command never produces `mac_start`.
- R4: A command with bit 8 (force) set gives a one-cycle `buf_flush` pulse in the following cycle.
- R5: A force command issued while a frame is active, and with no abort already running, gives a one-cycle `mac_abort` pulse in the following cycle. `mac_bad_crc` rises in that same cycle and stays high until the abort ends.
- R6: An abort ends in the cycle after `mac_abort_ack` is seen, or in the cycle after the 64th `bit_tick` counted while the abort runs, with no ack in that cycle. The second case gives a one-cycle `abort_err` pulse. `frame_active` clears when the abort ends.
- R7: `retry_limit` is 1 when bit 9 of the last command is set and 16 when it is clear.
- R8: `rb_data` returns bits [15:6] of the last command with 6'b001001 in bits [5:0]. `crc_inhibit` follows bit 12 and `pad_disable` follows bit 13.
- R9: `mac_done` clears `frame_active`. A command armed while a frame is active starts no earlier than the cycle after `frame_active` has cleared.
- R10: After reset, `mac_start`, `len_reject`, `buf_flush`, `mac_abort`, `mac_bad_crc`, `abort_err` and `frame_active` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_wr | input | 1 | Command write strobe |
| cmd_data | input | 16 | Command word |
| cmd_len | input | LEN_W | Frame length in bytes, taken with the command |
| byte_push | input | 1 | One byte entered the transmit buffer |
| mac_done | input | 1 | MAC finished the active frame |
| mac_abort_ack | input | 1 | MAC confirms the abort |
| bit_tick | input | 1 | One strobe per line bit time |
| mac_start | output | 1 | Begin-transmission pulse |
| mac_abort | output | 1 | Abort strobe to the MAC |
| mac_bad_crc | output | 1 | Corrupt the CRC of the frame being cut |
| buf_flush | output | 1 | Discard queued buffer contents |
| abort_err | output | 1 | Abort deadline expired without an ack |
| len_reject | output | 1 | Command refused because the length is too short |
| frame_active | output | 1 | A started frame is on the wire |
| retry_limit | output | 5 | Permitted collision count |
| crc_inhibit | output | 1 | No CRC is appended |
| pad_disable | output | 1 | Short frames are not padded |
| rb_data | output | 16 | Readback of the last command |

## Verification
The assertions assume the MAC raises `mac_done` or `mac_abort_ack` only while a frame is active. They also assume `mac_done` does not arrive during an abort. The bench drives handshake inputs only at those times and never issues a second force command while an abort is running. Byte pushes stay below the counter's saturation value, and a behavioural model follows the decoded fields, the byte count and the abort deadline on every clock.

// File: rtl/tx_cmd_pkg.sv
// Shared constants and field positions for the transmit command controller.
// Assumes a 16-bit command word whose field positions are fixed by software.
package tx_cmd_pkg;
    localparam int unsigned CMD_W      = 16;
    localparam int unsigned BIT_FORCE  = 8;
    localparam int unsigned BIT_ONECOL = 9;
    localparam int unsigned BIT_NOCRC  = 12;
    localparam int unsigned BIT_NOPAD  = 13;
    localparam int unsigned MODE_LO    = 6;
    localparam logic [5:0]  CMD_ID     = 6'b001001;

    typedef enum logic [1:0] {
        GO_EARLY_A = 2'b00,
        GO_EARLY_B = 2'b01,
        GO_EARLY_C = 2'b10,
        GO_WHOLE   = 2'b11
    } go_mode_e;
endpackage

// File: rtl/tx_cmd_decode.sv
// Holds the last command word and decodes it. It computes the effective start
// threshold and the length check for a command arriving now, and drives the
// retry limit, flags and readback from the stored word.
// Assumes cmd_len is stable in the cycle cmd_wr is high.
module tx_cmd_decode
    import tx_cmd_pkg::*;
#(
    parameter int unsigned LEN_W    = 11,
    parameter int unsigned THR_A    = 5,
    parameter int unsigned THR_B    = 381,
    parameter int unsigned THR_C    = 1021,
    parameter int unsigned MIN_LEN  = 3,
    parameter int unsigned MAX_COLL = 16,
    parameter int unsigned RETRY_W  = $clog2(MAX_COLL + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_wr,
    input  logic [CMD_W-1:0]   cmd_data,
    input  logic [LEN_W-1:0]   cmd_len,
    output logic [LEN_W-1:0]   thr_new,
    output logic               len_ok_new,
    output logic               force_new,
    output logic [RETRY_W-1:0] retry_limit,
    output logic               crc_inhibit,
    output logic               pad_disable,
    output logic [CMD_W-1:0]   rb_data
);
    logic [CMD_W-1:0] word_q;
    logic             seen_q;
    logic [LEN_W-1:0] base_thr;
    go_mode_e         mode;

    // Stored command word; deliberately left without a reset value.
    always_ff @(posedge clk) begin
        if (cmd_wr) word_q <= cmd_data;
    end

    // Tracks whether any command has been written since reset.
    always_ff @(posedge clk) begin
        if (!rst_n)      seen_q <= 1'b0;
        else if (cmd_wr) seen_q <= 1'b1;
    end

    // Threshold selection for the incoming command, clipped to its length.
    always_comb begin
        mode = go_mode_e'(cmd_data[MODE_LO+1:MODE_LO]);
        unique case (mode)
            GO_EARLY_A: base_thr = LEN_W'(THR_A);
            GO_EARLY_B: base_thr = LEN_W'(THR_B);
            GO_EARLY_C: base_thr = LEN_W'(THR_C);
            default:    base_thr = cmd_len;
        endcase
        thr_new = (base_thr < cmd_len) ? base_thr : cmd_len;
    end

    assign len_ok_new  = (cmd_len >= LEN_W'(MIN_LEN));
    assign force_new   = cmd_wr & cmd_data[BIT_FORCE];
    assign retry_limit = word_q[BIT_ONECOL] ? RETRY_W'(1) : RETRY_W'(MAX_COLL);
    assign crc_inhibit = word_q[BIT_NOCRC];
    assign pad_disable = word_q[BIT_NOPAD];
    assign rb_data     = {word_q[CMD_W-1:6], CMD_ID};

    p_retry_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q |-> (retry_limit == RETRY_W'(1) || retry_limit == RETRY_W'(MAX_COLL)));
    p_word_tracks_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr |=> (rb_data[CMD_W-1:6] == $past(cmd_data[CMD_W-1:6])));
endmodule

// File: rtl/tx_start_gate.sv
// Counts buffered bytes for the current command and issues the MAC start pulse
// once the latched threshold is met. It owns the frame-active state.
// Assumes mac_done and abort_done arrive only while a frame is active.
module tx_start_gate #(
    parameter int unsigned LEN_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_wr,
    input  logic [LEN_W-1:0] thr_new,
    input  logic             len_ok_new,
    input  logic             byte_push,
    input  logic             mac_done,
    input  logic             abort_done,
    output logic             mac_start,
    output logic             len_reject,
    output logic             frame_active
);
    localparam logic [LEN_W-1:0] CNT_MAX = '1;

    logic [LEN_W-1:0] cnt_q, cnt_nxt, thr_q;
    logic             armed_q, start_q, rej_q, active_q, go;

    // Next byte count; saturates at the counter maximum.
    always_comb begin
        cnt_nxt = cnt_q;
        if (byte_push && cnt_q != CNT_MAX) cnt_nxt = cnt_q + 1'b1;
        go = armed_q && !active_q && (cnt_nxt >= thr_q);
    end

    // Command latch, byte counter and start decision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            thr_q   <= '0;
            armed_q <= 1'b0;
            start_q <= 1'b0;
            rej_q   <= 1'b0;
        end else if (cmd_wr) begin
            cnt_q   <= byte_push ? LEN_W'(1) : '0;
            thr_q   <= thr_new;
            armed_q <= len_ok_new;
            start_q <= 1'b0;
            rej_q   <= !len_ok_new;
        end else begin
            cnt_q   <= cnt_nxt;
            start_q <= go;
            rej_q   <= 1'b0;
            if (go) armed_q <= 1'b0;
        end
    end

    // Frame-active state: set by a start, cleared by completion or abort.
    always_ff @(posedge clk) begin
        if (!rst_n)                               active_q <= 1'b0;
        else if (active_q && (mac_done || abort_done)) active_q <= 1'b0;
        else if (go && !cmd_wr)                   active_q <= 1'b1;
    end

    assign mac_start    = start_q;
    assign len_reject   = rej_q;
    assign frame_active = active_q;

    p_start_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mac_start |=> !mac_start);
    p_start_marks_active_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mac_start |-> frame_active);
    p_reject_no_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        len_reject |-> !mac_start);
    p_reject_disarms_r3: assert property (@(posedge clk) disable iff (!rst_n)
        len_reject |=> !mac_start);
    p_done_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_active && mac_done) |=> !frame_active);
endmodule

// File: rtl/tx_abort_seq.sv
// Runs the forced-abort sequence: flush pulse, abort strobe, bad-CRC hold and
// a bit-time deadline that ends the abort with an error if the MAC stays silent.
// Assumes bit_tick pulses once per line bit time.
module tx_abort_seq #(
    parameter int unsigned DEADLINE = 64,
    parameter int unsigned DL_W     = $clog2(DEADLINE + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic force_cmd,
    input  logic frame_active,
    input  logic mac_abort_ack,
    input  logic bit_tick,
    output logic mac_abort,
    output logic mac_bad_crc,
    output logic buf_flush,
    output logic abort_err,
    output logic abort_done
);
    localparam logic [DL_W-1:0] DL_LAST = DL_W'(DEADLINE - 1);

    logic            abt_q, strobe_q, flush_q, err_q, expire;
    logic [DL_W-1:0] dl_q;

    assign expire     = abt_q && !mac_abort_ack && bit_tick && (dl_q == DL_LAST);
    assign abort_done = abt_q && (mac_abort_ack || expire);

    // Abort state and deadline counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            abt_q    <= 1'b0;
            dl_q     <= '0;
            strobe_q <= 1'b0;
        end else if (abt_q) begin
            strobe_q <= 1'b0;
            if (abort_done) begin
                abt_q <= 1'b0;
                dl_q  <= '0;
            end else if (bit_tick) begin
                dl_q  <= dl_q + 1'b1;
            end
        end else begin
            strobe_q <= force_cmd && frame_active;
            abt_q    <= force_cmd && frame_active;
            dl_q     <= '0;
        end
    end

    // One-cycle flush and error pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flush_q <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            flush_q <= force_cmd;
            err_q   <= expire;
        end
    end

    assign mac_abort   = strobe_q;
    assign mac_bad_crc = abt_q;
    assign buf_flush   = flush_q;
    assign abort_err   = err_q;

    p_flush_follows_force_r4: assert property (@(posedge clk) disable iff (!rst_n)
        buf_flush |-> $past(force_cmd));
    p_strobe_with_badcrc_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mac_abort |-> mac_bad_crc);
    p_strobe_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mac_abort |=> !mac_abort);
    p_deadline_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mac_bad_crc |-> (dl_q < DL_W'(DEADLINE)));
    p_err_ends_abort_r6: assert property (@(posedge clk) disable iff (!rst_n)
        abort_err |-> !mac_bad_crc);
    p_ack_ends_abort_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mac_bad_crc && mac_abort_ack) |=> (!mac_bad_crc && !abort_err));
endmodule

// File: rtl/tx_cmd_ctrl.sv
// Top of the transmit command controller: wires the command decoder, the
// start gate and the abort sequencer together.
// Assumes a single host writer and a MAC that follows the start/abort handshake.
module tx_cmd_ctrl
    import tx_cmd_pkg::*;
#(
    parameter int unsigned LEN_W    = 11,
    parameter int unsigned THR_A    = 5,
    parameter int unsigned THR_B    = 381,
    parameter int unsigned THR_C    = 1021,
    parameter int unsigned MIN_LEN  = 3,
    parameter int unsigned MAX_COLL = 16,
    parameter int unsigned DEADLINE = 64,
    parameter int unsigned RETRY_W  = $clog2(MAX_COLL + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_wr,
    input  logic [15:0]        cmd_data,
    input  logic [LEN_W-1:0]   cmd_len,
    input  logic               byte_push,
    input  logic               mac_done,
    input  logic               mac_abort_ack,
    input  logic               bit_tick,
    output logic               mac_start,
    output logic               mac_abort,
    output logic               mac_bad_crc,
    output logic               buf_flush,
    output logic               abort_err,
    output logic               len_reject,
    output logic               frame_active,
    output logic [RETRY_W-1:0] retry_limit,
    output logic               crc_inhibit,
    output logic               pad_disable,
    output logic [15:0]        rb_data
);
    logic [LEN_W-1:0] thr_new;
    logic             len_ok_new, force_new, abort_done;

    tx_cmd_decode #(
        .LEN_W(LEN_W), .THR_A(THR_A), .THR_B(THR_B), .THR_C(THR_C),
        .MIN_LEN(MIN_LEN), .MAX_COLL(MAX_COLL), .RETRY_W(RETRY_W)
    ) u_decode (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_data(cmd_data),
        .cmd_len(cmd_len), .thr_new(thr_new), .len_ok_new(len_ok_new),
        .force_new(force_new), .retry_limit(retry_limit),
        .crc_inhibit(crc_inhibit), .pad_disable(pad_disable), .rb_data(rb_data)
    );

    tx_start_gate #(.LEN_W(LEN_W)) u_gate (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .thr_new(thr_new),
        .len_ok_new(len_ok_new), .byte_push(byte_push), .mac_done(mac_done),
        .abort_done(abort_done), .mac_start(mac_start),
        .len_reject(len_reject), .frame_active(frame_active)
    );

    tx_abort_seq #(.DEADLINE(DEADLINE)) u_abort (
        .clk(clk), .rst_n(rst_n), .force_cmd(force_new),
        .frame_active(frame_active), .mac_abort_ack(mac_abort_ack),
        .bit_tick(bit_tick), .mac_abort(mac_abort), .mac_bad_crc(mac_bad_crc),
        .buf_flush(buf_flush), .abort_err(abort_err), .abort_done(abort_done)
    );

    p_idle_after_reset_r10: assert property (@(posedge clk)
        !$past(rst_n) |-> (!mac_start && !mac_abort && !frame_active && !len_reject));
    p_abort_needs_frame_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mac_bad_crc) |-> $past(frame_active));
endmodule

// File: tb/tb_tx_cmd_ctrl.sv
module tb_tx_cmd_ctrl;
    localparam int LW = 11;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_wr = 1'b0, byte_push = 1'b0, mac_done = 1'b0, ack = 1'b0, tick = 1'b0;
    logic [15:0] cmd_data = '0;
    logic [LW-1:0] cmd_len = '0;
    logic mac_start, mac_abort, bad_crc, flush, aerr, rej, active, nocrc, nopad;
    logic [4:0] retry;
    logic [15:0] rb;

    always #2 clk = ~clk;

    tx_cmd_ctrl dut (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_data(cmd_data),
        .cmd_len(cmd_len), .byte_push(byte_push), .mac_done(mac_done),
        .mac_abort_ack(ack), .bit_tick(tick), .mac_start(mac_start),
        .mac_abort(mac_abort), .mac_bad_crc(bad_crc), .buf_flush(flush),
        .abort_err(aerr), .len_reject(rej), .frame_active(active),
        .retry_limit(retry), .crc_inhibit(nocrc), .pad_disable(nopad),
        .rb_data(rb)
    );

    int checks = 0, fails = 0;
    bit started = 0, finished = 0;

    // Behavioural reference state.
    int m_cnt, m_thr, m_dl;
    bit m_armed, m_act, m_ab, m_st, m_abp, m_fl, m_rej, m_err, m_seen;
    logic [15:0] m_cmd;

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int eff_thr(logic [15:0] w, int len);
        int b;
        case (w[7:6])
            2'b00: b = 5;
            2'b01: b = 381;
            2'b10: b = 1021;
            default: b = len;
        endcase
        return (b < len) ? b : len;
    endfunction

    // Reference model step on every rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_thr = 0; m_dl = 0; m_armed = 0; m_act = 0; m_ab = 0;
            m_st = 0; m_abp = 0; m_fl = 0; m_rej = 0; m_err = 0; m_seen = 0;
        end else begin
            bit expd, dn, frc, st;
            int nxt;
            expd = m_ab && !ack && tick && (m_dl == 63);
            dn   = m_ab && (ack || (tick && m_dl == 63));
            frc  = cmd_wr && cmd_data[8];
            m_abp = 0; m_rej = 0; m_err = expd; m_fl = frc; st = 0;
            if (m_ab) begin
                if (dn) begin m_ab = 0; m_dl = 0; end
                else if (tick) m_dl++;
            end else if (frc && m_act) begin
                m_ab = 1; m_dl = 0; m_abp = 1;
            end
            if (cmd_wr) begin
                m_cmd = cmd_data; m_seen = 1;
                m_cnt = byte_push ? 1 : 0;
                m_armed = (cmd_len >= 3);
                m_rej = (cmd_len < 3);
                m_thr = eff_thr(cmd_data, int'(cmd_len));
            end else begin
                nxt = m_cnt + ((byte_push && m_cnt < 2047) ? 1 : 0);
                m_cnt = nxt;
                if (m_armed && !m_act && nxt >= m_thr) begin st = 1; m_armed = 0; end
            end
            if (m_act && (mac_done || dn)) m_act = 0;
            else if (st) m_act = 1;
            m_st = st;
        end
        started = 1;
    end

    // Compare outputs with the model away from the active edge.
    always @(negedge clk) begin
        if (started && !finished) begin
            if (!rst_n || $time < 12) begin
                chk("R10 start", mac_start, 0);
                chk("R10 active", active, 0);
                chk("R10 abort", mac_abort, 0);
                chk("R10 badcrc", bad_crc, 0);
            end else begin
                chk("R1 start", mac_start, m_st);
                if (mac_start) chk("R2 active-with-start", active, 1);
                chk("R3 reject", rej, m_rej);
                chk("R4 flush", flush, m_fl);
                chk("R5 abort", mac_abort, m_abp);
                chk("R5 badcrc", bad_crc, m_ab);
                chk("R6 err", aerr, m_err);
                chk("R9 active", active, m_act);
                if (m_seen) begin
                    chk("R7 retry", retry, m_cmd[9] ? 1 : 16);
                    chk("R8 rb", rb, {m_cmd[15:6], 6'b001001});
                    chk("R8 nocrc", nocrc, m_cmd[12]);
                    chk("R8 nopad", nopad, m_cmd[13]);
                end
            end
        end
    end

    task automatic cmd(logic [15:0] w, int len);
        @(negedge clk);
        cmd_wr = 1; cmd_data = w; cmd_len = LW'(len);
        @(negedge clk);
        cmd_wr = 0;
    endtask

    task automatic push(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); byte_push = 1;
        end
        @(negedge clk); byte_push = 0;
    endtask

    task automatic done_pulse();
        @(negedge clk); mac_done = 1;
        @(negedge clk); mac_done = 0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        idle(3);
        @(negedge clk); rst_n = 1;
        idle(2);
        // R1 mode 00: start after 5 bytes
        cmd(16'h0009, 60); push(10); idle(2); done_pulse();
        // R1 mode 01 with retry bit (R7) and flags (R8)
        cmd(16'h3249, 500); push(381); idle(2); done_pulse();
        // R1 mode 10
        cmd(16'h0089, 1500); push(1030); done_pulse();
        // R1 full frame
        cmd(16'h10C9, 40); push(40); done_pulse();
        // R1 mode 10 clipped to length
        cmd(16'h0089, 100); push(100); done_pulse();
        // R3 length 2 rejected, no start
        cmd(16'h0009, 2); push(8); idle(3);
        // R3 boundary: length 3 accepted
        cmd(16'h0009, 3); push(3); done_pulse();
        // R5/R6 force during frame, ack after some cycles
        cmd(16'h0009, 60); push(6);
        cmd(16'h0109, 60); idle(8);
        @(negedge clk); ack = 1; @(negedge clk); ack = 0; idle(2);
        // new forced command started afterwards; finish it
        push(5); done_pulse();
        // R6 deadline expiry with every-cycle ticks
        cmd(16'h0009, 60); push(5);
        @(negedge clk); tick = 1;
        cmd(16'h0109, 60); idle(70);
        @(negedge clk); tick = 0; idle(2);
        // R4 force while idle only flushes
        cmd(16'h0109, 10); idle(3); push(10); done_pulse();
        // R9 command armed during active frame waits for done
        cmd(16'h0009, 60); push(5);
        cmd(16'h0009, 60); push(7); idle(3); done_pulse(); idle(3); done_pulse();
        idle(4);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; fails++;
            $display("FAIL watchdog run did not complete");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule